// File: doc/BRIEF.md
# Thermal Threshold Alarm Controller

This block watches an 8-bit temperature code supplied by a sensor front end and raises alarms when that code crosses programmed limits. Each alarm has three rising levels and three falling levels. A rising level fires when a new sample moves the code from below its limit to at or above it. A falling level fires when a new sample moves the code from above its limit to at or below it. Each event sets a sticky status bit. Status bits are masked by an enable register and merged into one interrupt line.

Samples enter on a valid/ready stream. `samp_ready` is held high at all times, so the block never applies back-pressure. A sample is accepted on every clock edge where `samp_valid` is high. The code held between samples is the reference for the next crossing test. Software reaches the registers through a word-addressed bus. Writes are single-cycle and reads are combinational. The bus gives access to both packed threshold registers, the enable mask, the status register, a write-one-to-clear port and the latest temperature code.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset, every register reads zero, the held temperature is zero and `irq` is low.
- R2: Rising level x (x = 0..2) sets status bit 4*x on an accepted sample when the held code is below the rising limit of level x and the new code is at or above it.
- R3: Falling level x sets status bit 4*(3+x), which is bit 12, 16 or 20, on an accepted sample when the held code is above the falling limit of level x and the new code is at or below it.
- R4: A sample that leaves the code on the same side of a limit sets no status bit for that limit. This includes a sample that stays at or above a rising limit.
- R5: A status bit stays set until it is cleared, even after the code crosses back.
- R6: Writing word 4 (the clear port) clears each status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged. A write to word 3 (status) has no effect. Word 4 reads zero.
- R7: If a clear and a new event for the same bit occur in the same cycle, the bit ends up set.
- R8: `irq` equals the OR over the six alarm bits of (status AND enable). Status bits record events while their enable bits are off.
- R9: Word 5 returns the held temperature code in bits [7:0], and bits [31:8] read zero. The held code changes only on an accepted sample.
- R10: Word 0 (rising limits) and word 1 (falling limits) hold level x in bits [8x+7:8x]. Bits [31:24] of both read zero. Word 2 (enable) keeps only bits 0, 4, 8, 12, 16 and 20, and all other bits read zero. Unmapped words read zero.
- R11: `samp_ready` is high at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | A temperature sample is offered |
| samp_ready | output | 1 | Sample accepted (held high) |
| samp_code | input | 8 | Temperature code of the sample |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined alarm interrupt |

## Verification
The bench builds the block with its default parameters: three levels, an 8-bit code and a 32-bit register word. These defaults place the falling bits at 12, 16 and 20 and leave a reserved top byte in each threshold word. The bench can therefore reach the interleaved bit layout, the reserved-byte masking and every level's crossing in both directions. Stimulus includes a sample that lands exactly on a limit, a sample that stays on one side, a descent that crosses two falling levels at once, and a clear that coincides with a fresh crossing.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned TEMP_W  = 8;
  localparam int unsigned LEVELS  = 3;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned STRIDE  = 4;

  localparam logic [ADDR_W-1:0] A_THR_RISE = 3'd0;
  localparam logic [ADDR_W-1:0] A_THR_FALL = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR    = 3'd4;
  localparam logic [ADDR_W-1:0] A_TEMP     = 3'd5;

  // Rising level x sits at STRIDE*x, falling level x at STRIDE*(LEVELS+x).
  function automatic logic [DATA_W-1:0] alarm_bits_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < 2 * LEVELS; i++) m[STRIDE*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ta_sample_reg.sv
module ta_sample_reg #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [TEMP_W-1:0] code,
  output logic [TEMP_W-1:0] held,
  output logic              fire
);
  assign fire = valid;

  always_ff @(posedge clk) begin
    if (!rst_n)     held <= '0;
    else if (valid) held <= code;
  end

  assert_temp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(held));
endmodule

// File: rtl/ta_level_detect.sv
module ta_level_detect #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              fire,
  input  logic [TEMP_W-1:0] prev_code,
  input  logic [TEMP_W-1:0] new_code,
  input  logic [TEMP_W-1:0] lim_rise,
  input  logic [TEMP_W-1:0] lim_fall,
  output logic              rise_evt,
  output logic              fall_evt
);
  // Crossing tests relative to the code held from the prior sample.
  assign rise_evt = fire && (prev_code < lim_rise) && (new_code >= lim_rise);
  assign fall_evt = fire && (prev_code > lim_fall) && (new_code <= lim_fall);
endmodule

// File: rtl/ta_status_bank.sv
module ta_status_bank #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((status & $past(status)) == $past(status)));
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(set_vec)) == '0);
endmodule

// File: rtl/ta_regfile.sv
module ta_regfile
  import thermal_alarm_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned TW     = TEMP_W,
  parameter int unsigned NLVL   = LEVELS,
  parameter int unsigned AW     = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status,
  input  logic [TW-1:0] temp,
  output logic [DW-1:0] thr_rise,
  output logic [DW-1:0] thr_fall,
  output logic [DW-1:0] enable,
  output logic [DW-1:0] clr_vec,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] ALARM_MASK = alarm_bits_mask();
  localparam int unsigned   THR_BITS   = TW * NLVL;
  localparam logic [DW-1:0] THR_MASK   = {{(DW-THR_BITS){1'b0}}, {THR_BITS{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_rise <= '0;
      thr_fall <= '0;
      enable   <= '0;
    end else if (wr) begin
      if (addr == A_THR_RISE) thr_rise <= wdata & THR_MASK;
      if (addr == A_THR_FALL) thr_fall <= wdata & THR_MASK;
      if (addr == A_ENABLE)   enable   <= wdata & ALARM_MASK;
    end
  end

  assign clr_vec = (wr && addr == A_CLEAR) ? (wdata & ALARM_MASK) : '0;

  always_comb begin
    unique case (addr)
      A_THR_RISE: rdata = thr_rise;
      A_THR_FALL: rdata = thr_fall;
      A_ENABLE:   rdata = enable;
      A_STATUS:   rdata = status;
      A_TEMP:     rdata = {{(DW-TW){1'b0}}, temp};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned TW   = TEMP_W,
  parameter int unsigned NLVL = LEVELS,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  output logic          samp_ready,
  input  logic [TW-1:0] samp_code,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [TW-1:0] held;
  logic          fire;
  logic [DW-1:0] thr_rise, thr_fall, enable, clr_vec, status, set_vec;
  logic [NLVL-1:0] rise_evt, fall_evt;

  assign samp_ready = 1'b1;

  ta_sample_reg #(.TEMP_W(TW)) u_sample (
    .clk(clk), .rst_n(rst_n), .valid(samp_valid), .code(samp_code),
    .held(held), .fire(fire));

  ta_regfile #(.DW(DW), .TW(TW), .NLVL(NLVL), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .temp(held), .thr_rise(thr_rise), .thr_fall(thr_fall),
    .enable(enable), .clr_vec(clr_vec), .rdata(reg_rdata));

  for (genvar x = 0; x < NLVL; x++) begin : g_lvl
    ta_level_detect #(.TEMP_W(TW)) u_det (
      .fire(fire), .prev_code(held), .new_code(samp_code),
      .lim_rise(thr_rise[TW*x +: TW]), .lim_fall(thr_fall[TW*x +: TW]),
      .rise_evt(rise_evt[x]), .fall_evt(fall_evt[x]));
  end

  always_comb begin
    set_vec = '0;
    for (int x = 0; x < NLVL; x++) begin
      set_vec[STRIDE*x]        = rise_evt[x];
      set_vec[STRIDE*(NLVL+x)] = fall_evt[x];
    end
  end

  ta_status_bank #(.DATA_W(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .status(status));

  assign irq = |(status & enable);

  assert_masked_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt[0] |=> status[0]);
  assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt[0] |=> status[STRIDE*NLVL]);
  assert_ready_high_R11: assert property (@(posedge clk) samp_ready);
endmodule

// File: tb/thermal_alarm_ctrl_tb.sv
module thermal_alarm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [7:0]  samp_code = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  thermal_alarm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_code(samp_code), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  // Monitor: pops expected items and compares against the live outputs.
  initial forever begin
    @(chk_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 1) ? {31'b0, irq} : (it.kind == 2) ? {31'b0, samp_ready} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    q.push_back('{0, e, tag});
    ->chk_ev;
    #2;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk);
    q.push_back('{1, {31'b0, e}, tag});
    ->chk_ev;
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic sample(input logic [7:0] c);
    @(negedge clk);
    samp_valid = 1'b1; samp_code = c;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic sample_clear(input logic [7:0] c, input logic [31:0] m);
    @(negedge clk);
    samp_valid = 1'b1; samp_code = c;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = m;
    @(negedge clk);
    samp_valid = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R11 during reset
    @(negedge clk);
    q.push_back('{2, 32'h1, "R11 ready in reset"}); ->chk_ev; #2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) exp_rd(a[2:0], 32'h0, "R1 reset register zero");
    exp_irq(1'b0, "R1 irq low after reset");

    // R10 packing and masking
    wr(3'd0, 32'hFF5A4632);          // rise: 50, 70, 90
    wr(3'd1, 32'hEE55412D);          // fall: 45, 65, 85
    wr(3'd2, 32'hFFFFFFFF);
    exp_rd(3'd0, 32'h005A4632, "R10 rising limits top byte zero");
    exp_rd(3'd1, 32'h0055412D, "R10 falling limits top byte zero");
    exp_rd(3'd2, 32'h00111111, "R10 enable keeps alarm bits only");
    wr(3'd2, 32'h0);

    sample(8'd40);
    exp_rd(3'd3, 32'h0, "R4 no crossing below limits");
    exp_rd(3'd5, 32'h00000028, "R9 temperature readout 40");

    sample(8'd55);
    exp_rd(3'd3, 32'h00000001, "R2 rising level 0 at 55");
    exp_irq(1'b0, "R8 recorded but masked");

    sample(8'd60);
    exp_rd(3'd3, 32'h00000001, "R4 staying above adds nothing");

    wr(3'd2, 32'h00000001);
    exp_irq(1'b1, "R8 enabled bit drives irq");
    wr(3'd2, 32'h00000010);
    exp_irq(1'b0, "R8 other enable bit no irq");
    wr(3'd2, 32'h00111111);

    sample(8'd95);
    exp_rd(3'd3, 32'h00000111, "R2 rising levels 1 and 2");

    sample(8'd80);
    exp_rd(3'd3, 32'h00100111, "R3 falling level 2 and R5 sticky rising");

    wr(3'd4, 32'h00000001);
    exp_rd(3'd3, 32'h00100110, "R6 one clears bit 0");
    wr(3'd4, 32'h0);
    exp_rd(3'd3, 32'h00100110, "R6 zero clear no effect");
    wr(3'd3, 32'hFFFFFFFF);
    exp_rd(3'd3, 32'h00100110, "R6 status write ignored");
    exp_rd(3'd4, 32'h0, "R6 clear port reads zero");

    sample(8'd65);
    exp_rd(3'd3, 32'h00110110, "R3 falling level 1 landing on limit");

    sample_clear(8'd70, 32'h00000110);
    exp_rd(3'd3, 32'h00110010, "R7 set wins over clear");

    wr(3'd4, 32'hFFFFFFFF);
    exp_rd(3'd3, 32'h0, "R6 clear all");
    exp_irq(1'b0, "R8 irq low when status empty");

    sample(8'd40);
    exp_rd(3'd3, 32'h00011000, "R3 falling levels 0 and 1");
    exp_irq(1'b1, "R8 irq from falling alarm");

    @(negedge clk);
    samp_valid = 1'b0; samp_code = 8'd200;
    @(negedge clk);
    exp_rd(3'd5, 32'h00000028, "R9 held code unchanged without valid");
    exp_rd(3'd3, 32'h00011000, "R4 unaccepted code sets nothing");
    @(negedge clk);
    q.push_back('{2, 32'h1, "R11 ready high"}); ->chk_ev; #2;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule